// File: doc/BRIEF.md
# Windowed Five-Channel Pulse Counter

This block counts rising edges on five independent single-bit pulse inputs during a repeating counting window. The window length is a number of clock cycles held in a register. When a window closes, the five running counts are written as one record into an on-chip circular buffer, and counting starts again without a gap. A control bit starts and stops the counting.

A host reads the stored records, and the control, length and record-count registers, through a simple read strobe port. Every read has the same pipelined latency. The word address is registered twice before the buffer is read, and the data comes back with a one-cycle acknowledge. The inputs are expected to be clean, synchronous pulses. Level conversion and pulse stretching happen upstream.

Top module: `pulse_window_counter`

## Requirements
- R1: Each channel counts a rising edge when its input is high and the registered copy of that input from the previous cycle is low. An input held high over many cycles adds exactly one count.
- R2: A channel count never wraps. It stops at 2^CNT_W-1 and stays there until the window closes.
- R3: While counting is enabled, a window closes in every cycle where the window timer has reached the active length minus one. In that cycle the current counts are stored and each counter restarts at 1 if its channel shows an edge in that same cycle, otherwise at 0.
- R4: A record is stored in slot (write pointer mod 2^REC_AW), so slots are reused circularly. In the buffer region (byte address bit ADDR_W-1 set), the word index is the byte address shifted right by two. Within that index, bits [2:0] pick the channel and the bits above them pick the slot. Channel indexes 5 to 7 read as zero.
- R5: Register word 2 holds the write pointer. It starts at 0 after reset and increases by exactly one for each closed window.
- R6: Register word 0 bit 0 enables counting and reads back its value. While it is clear, all counters and the window timer are held at zero and no record is stored. Setting it starts a fresh window at timer zero.
- R7: Register word 1 holds the window length in cycles, with reset value MAX_WIN. A written value is clamped into the range [MIN_WIN, MAX_WIN], and the clamped value is what reads back. A new length is applied only at the next window close, or when counting is next enabled.
- R8: A read strobe sampled at a clock edge returns its data with bus_ack_o high for exactly one cycle, four cycles after the strobe cycle. A strobe in every cycle is accepted, and each one is acknowledged in order.
- R9: Writes to the buffer region and to the write-pointer register are ignored. Register words other than 0, 1 and 2 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | NUM_CH | Conditioned pulse inputs, one bit per channel |
| bus_rd_i | input | 1 | Read strobe, one word per cycle |
| bus_wr_i | input | 1 | Write strobe, applied at the clock edge |
| bus_addr_i | input | ADDR_W | Byte address shared by reads and writes |
| bus_wdata_i | input | DATA_W | Write data |
| bus_ack_o | output | 1 | One-cycle read acknowledge |
| bus_rdata_o | output | DATA_W | Read data, valid while bus_ack_o is high |

## Verification
Two pairs of events can land in the same cycle: a window close together with a fresh rising edge, and a host read of a buffer slot together with the store of a new record into that slot. Both are provoked by running random toggling pulses with short windows while bursts of back-to-back reads sweep the whole buffer. A behavioural model predicts every acknowledge and every returned word cycle by cycle. It credits a close-cycle edge to the next window, and it returns the slot contents from before the store to a read that meets the store in its memory stage.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LEN  = 2'd1,
    REG_WPTR = 2'd2
  } pwc_reg_e;
endpackage

// File: rtl/pwc_pulse_counter.sv
module pwc_pulse_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             en_i,
  input  logic             close_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic prev_q;
  logic rise;

  assign rise = pulse_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cnt_o  <= '0;
    end else begin
      prev_q <= pulse_i;
      if (!en_i)                       cnt_o <= '0;
      else if (close_i)                cnt_o <= CNT_W'(rise); // close-cycle edge goes to new window
      else if (rise && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end
  end

  a_r2_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !close_i && cnt_o == CNT_MAX |=> cnt_o == CNT_MAX);
  a_r1_level_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !close_i && !(pulse_i && !prev_q) |=> $stable(cnt_o));
  a_r3_restart_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |=> cnt_o <= CNT_W'(1));
  a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_o == '0);
endmodule

// File: rtl/pwc_window_timer.sv
module pwc_window_timer #(
  parameter int TW      = 27,
  parameter int MIN_WIN = 125,
  parameter int MAX_WIN = 125_000_000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [TW-1:0] len_i,
  output logic          close_o
);
  logic [TW-1:0] tmr_q;
  logic [TW-1:0] cur_len_q;

  assign close_o = en_i && (tmr_q == cur_len_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q     <= '0;
      cur_len_q <= TW'(MAX_WIN);
    end else if (!en_i || close_o) begin
      tmr_q     <= '0;
      cur_len_q <= len_i; // length is applied only at a boundary
    end else begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  a_r7_len_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_len_q >= TW'(MIN_WIN) && cur_len_q <= TW'(MAX_WIN));
  a_r3_close_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |=> !close_o);
  a_r6_timer_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> tmr_q == '0);
endmodule

// File: rtl/pwc_record_buf.sv
module pwc_record_buf #(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 32,
  parameter int REC_AW = 8,
  parameter int CH_AW  = 3
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [REC_AW-1:0]       wslot_i,
  input  logic [NUM_CH*CNT_W-1:0] wdata_i,
  input  logic [REC_AW-1:0]       rslot_i,
  input  logic [CH_AW-1:0]        rch_i,
  output logic [CNT_W-1:0]        rdata_o
);
  localparam int DEPTH = 2 ** REC_AW;

  logic [CNT_W-1:0] bank_rd [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
    logic [CNT_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i) mem[wslot_i] <= wdata_i[g*CNT_W +: CNT_W];
    end
    assign bank_rd[g] = mem[rslot_i];
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rch_i == CH_AW'(c)) rdata_o = bank_rd[c];
    end
  end
endmodule

// File: rtl/pwc_read_pipe.sv
module pwc_read_pipe #(
  parameter int AW2    = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [AW2-1:0]    waddr_i,
  output logic [AW2-1:0]    s2_addr_o,
  input  logic [DATA_W-1:0] s2_data_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              s1_v, s2_v, s3_v;
  logic [AW2-1:0]    s1_a;
  logic [DATA_W-1:0] s3_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      s3_v      <= 1'b0;
      s1_a      <= '0;
      s2_addr_o <= '0;
      s3_d      <= '0;
      ack_o     <= 1'b0;
      rdata_o   <= '0;
    end else begin
      s1_v      <= rd_i;
      s1_a      <= waddr_i;
      s2_v      <= s1_v;
      s2_addr_o <= s1_a;
      s3_v      <= s2_v;
      s3_d      <= s2_data_i;
      ack_o     <= s3_v;
      rdata_o   <= s3_d;
    end
  end

  a_r8_ack_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> ##4 ack_o);
  a_r8_ack_has_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(rd_i, 4));
endmodule

// File: rtl/pulse_window_counter.sv
module pulse_window_counter #(
  parameter int NUM_CH  = 5,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int REC_AW  = 8,
  parameter int ADDR_W  = 14,
  parameter int MIN_WIN = 125,
  parameter int MAX_WIN = 125_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pulse_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              bus_ack_o,
  output logic [DATA_W-1:0] bus_rdata_o
);
  import pwc_pkg::*;

  localparam int CH_AW = 3;               // fixed 8-word record stride
  localparam int WA_W  = REC_AW + CH_AW;
  localparam int AW2   = ADDR_W - 2;
  localparam int RW    = AW2 - 1;
  localparam int TW    = $clog2(MAX_WIN + 1);

  logic                    en_q;
  logic [TW-1:0]           len_q;
  logic [DATA_W-1:0]       wptr_q;
  logic                    close;
  logic [NUM_CH*CNT_W-1:0] cnt_flat;
  logic [AW2-1:0]          s2_addr;
  logic [DATA_W-1:0]       s2_data;
  logic [CNT_W-1:0]        buf_word;
  logic                    wr_reg;
  logic [RW-1:0]           wr_word;

  assign wr_reg  = bus_wr_i && !bus_addr_i[ADDR_W-1];
  assign wr_word = bus_addr_i[ADDR_W-2:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      len_q  <= TW'(MAX_WIN);
      wptr_q <= '0;
    end else begin
      if (close) wptr_q <= wptr_q + 1'b1;
      if (wr_reg && wr_word == RW'(REG_CTRL)) en_q <= bus_wdata_i[0];
      if (wr_reg && wr_word == RW'(REG_LEN)) begin
        if (bus_wdata_i < DATA_W'(MIN_WIN))      len_q <= TW'(MIN_WIN);
        else if (bus_wdata_i > DATA_W'(MAX_WIN)) len_q <= TW'(MAX_WIN);
        else                                      len_q <= bus_wdata_i[TW-1:0];
      end
    end
  end

  pwc_window_timer #(.TW(TW), .MIN_WIN(MIN_WIN), .MAX_WIN(MAX_WIN)) i_timer (
    .clk_i, .rst_ni, .en_i(en_q), .len_i(len_q), .close_o(close)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwc_pulse_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk_i, .rst_ni, .pulse_i(pulse_i[g]), .en_i(en_q), .close_i(close),
      .cnt_o(cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  pwc_record_buf #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .REC_AW(REC_AW), .CH_AW(CH_AW)) i_buf (
    .clk_i,
    .we_i   (close),
    .wslot_i(wptr_q[REC_AW-1:0]),
    .wdata_i(cnt_flat),
    .rslot_i(s2_addr[WA_W-1:CH_AW]),
    .rch_i  (s2_addr[CH_AW-1:0]),
    .rdata_o(buf_word)
  );

  always_comb begin
    s2_data = '0;
    if (s2_addr[AW2-1]) begin
      s2_data = DATA_W'(buf_word);
    end else begin
      case (s2_addr[RW-1:0])
        RW'(REG_CTRL): s2_data = DATA_W'(en_q);
        RW'(REG_LEN):  s2_data = DATA_W'(len_q);
        RW'(REG_WPTR): s2_data = wptr_q;
        default:       s2_data = '0;
      endcase
    end
  end

  pwc_read_pipe #(.AW2(AW2), .DATA_W(DATA_W)) i_rd (
    .clk_i, .rst_ni,
    .rd_i     (bus_rd_i),
    .waddr_i  (bus_addr_i[ADDR_W-1:2]),
    .s2_addr_o(s2_addr),
    .s2_data_i(s2_data),
    .ack_o    (bus_ack_o),
    .rdata_o  (bus_rdata_o)
  );

  a_r5_wptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close |=> wptr_q == $past(wptr_q) + DATA_W'(1));
  a_r5_wptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !close |=> $stable(wptr_q));
  a_r6_no_store_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !close);
endmodule

// File: tb/test_pulse_window_counter.sv
module test_pulse_window_counter;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 5, CNT_W = 3, DATA_W = 32, REC_AW = 2, ADDR_W = 14;
  localparam int MIN_WIN = 4, MAX_WIN = 1000;
  localparam int CMAX = (1 << CNT_W) - 1;
  localparam int NSLOT = 1 << REC_AW;
  localparam int BUF_BASE = 1 << (ADDR_W - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NUM_CH-1:0] pulse = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic ack;
  logic [DATA_W-1:0] rdata;

  int n_checks = 0, n_fail = 0, pmode = 0, cyc = 0;
  bit done = 1'b0;
  string cur_req = "R8 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_window_counter #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .REC_AW(REC_AW),
    .ADDR_W(ADDR_W), .MIN_WIN(MIN_WIN), .MAX_WIN(MAX_WIN)) i_pulse_window_counter (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_ack_o(ack), .bus_rdata_o(rdata)
  );

  // behavioural model
  int m_en, m_len, m_cur, m_tmr, m_wptr;
  int m_cnt [NUM_CH];
  int m_prev [NUM_CH];
  int m_mem [NSLOT][8];
  int p1v, p1a, p2v, p2a, p3v, p3d, m_ackv, m_ackd;

  function automatic int mread(input int a);
    int wi;
    wi = (a >> 2) & ((1 << (ADDR_W - 3)) - 1);
    if ((a & BUF_BASE) != 0) return m_mem[(wi >> 3) % NSLOT][wi & 7];
    if (wi == 0) return m_en;
    if (wi == 1) return m_len;
    if (wi == 2) return m_wptr;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_len = MAX_WIN; m_cur = MAX_WIN; m_tmr = 0; m_wptr = 0;
      p1v = 0; p1a = 0; p2v = 0; p2a = 0; p3v = 0; p3d = 0; m_ackv = 0; m_ackd = 0;
      for (int c = 0; c < NUM_CH; c++) begin m_cnt[c] = 0; m_prev[c] = 0; end
      for (int s = 0; s < NSLOT; s++) for (int w = 0; w < 8; w++) m_mem[s][w] = 0;
    end else begin
      bit close;
      m_ackv = p3v; m_ackd = p3d;
      p3v = p2v; p3d = mread(p2a);
      p2v = p1v; p2a = p1a;
      p1v = rd; p1a = int'(addr);
      close = (m_en != 0) && (m_tmr == m_cur - 1);
      for (int c = 0; c < NUM_CH; c++) begin
        int rise;
        rise = (pulse[c] && m_prev[c] == 0) ? 1 : 0;
        if (m_en == 0) m_cnt[c] = 0;
        else if (close) begin m_mem[m_wptr % NSLOT][c] = m_cnt[c]; m_cnt[c] = rise; end
        else if (rise == 1 && m_cnt[c] < CMAX) m_cnt[c]++;
        m_prev[c] = pulse[c];
      end
      if (m_en == 0) begin m_tmr = 0; m_cur = m_len; end
      else if (close) begin m_wptr++; m_tmr = 0; m_cur = m_len; end
      else m_tmr++;
      if (wr && (int'(addr) & BUF_BASE) == 0) begin
        if ((addr >> 2) == 0) m_en = int'(wdata[0]);
        if ((addr >> 2) == 1) m_len = (wdata < MIN_WIN) ? MIN_WIN : (wdata > MAX_WIN) ? MAX_WIN : int'(wdata);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_checks++;
      if (ack !== m_ackv[0]) begin
        n_fail++;
        $display("FAIL %s ack act=%0b exp=%0b", cur_req, ack, m_ackv[0]);
      end else if (m_ackv != 0 && rdata !== DATA_W'(m_ackd)) begin
        n_fail++;
        $display("FAIL %s rdata act=%0d exp=%0d", cur_req, rdata, m_ackd);
      end
    end
  end

  // pulse stimulus
  always @(negedge clk) begin
    cyc++;
    case (pmode)
      1: begin
        pulse[0] <= ($urandom_range(0, 2) == 0) ? ~pulse[0] : pulse[0];
        pulse[1] <= ($urandom_range(0, 7) == 0) ? ~pulse[1] : pulse[1];
        pulse[2] <= 1'b1;
        pulse[3] <= (cyc % 7) < 3;
        pulse[4] <= ($urandom_range(0, 3) == 0) ? ~pulse[4] : pulse[4];
      end
      2: pulse <= NUM_CH'($urandom);
      default: pulse <= '0;
    endcase
  end

  task automatic bus_write(input int a, input int d);
    @(negedge clk); wr = 1'b1; addr = ADDR_W'(a); wdata = DATA_W'(d);
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input int a);
    @(negedge clk); rd = 1'b1; addr = ADDR_W'(a);
    @(negedge clk); rd = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic burst_read();
    for (int s = 0; s < NSLOT; s++) begin
      for (int w = 0; w < 8; w++) begin
        @(negedge clk); rd = 1'b1; addr = ADDR_W'(BUF_BASE + (s * 8 + w) * 4);
      end
    end
    @(negedge clk); rd = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R8 reset readback";
    bus_read(0); bus_read(4); bus_read(8);
    cur_req = "R7 length clamp";
    bus_write(4, 1); bus_read(4);
    bus_write(4, 5000); bus_read(4);
    bus_write(4, 40); bus_read(4);
    cur_req = "R1 edge counting";
    pmode = 1;
    bus_write(0, 1);
    repeat (230) @(negedge clk);
    cur_req = "R4 record layout and R8 back-to-back reads";
    burst_read();
    cur_req = "R5 write pointer";
    bus_read(8);
    cur_req = "R3 window boundary and R7 deferred length";
    bus_write(4, 7);
    repeat (100) @(negedge clk);
    burst_read();
    bus_read(8);
    cur_req = "R2 saturation";
    pmode = 2;
    bus_write(4, 60);
    repeat (200) @(negedge clk);
    burst_read();
    cur_req = "R9 ignored writes";
    bus_write(8, 0);
    bus_write(BUF_BASE, 123);
    bus_write(BUF_BASE + 4, 5);
    bus_read(8); bus_read(BUF_BASE); bus_read(BUF_BASE + 4); bus_read(12); bus_read(32);
    cur_req = "R6 enable control";
    bus_write(0, 0);
    repeat (50) @(negedge clk);
    bus_read(8);
    repeat (20) @(negedge clk);
    bus_read(8); bus_read(0);
    burst_read();
    bus_write(4, 4);
    bus_write(0, 1);
    repeat (30) @(negedge clk);
    burst_read();
    bus_read(8);
    pmode = 0;
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule